// File: doc/BRIEF.md
# Symmetric Lookup-Table FIR Equalizer

This block is a fixed-coefficient, T-spaced FIR equalizer for a receive path that delivers one signed sample per symbol. The tap count is odd (7 or 15) and the coefficient set is mirrored about the centre tap. Because the two samples that meet equal weights are summed first, only (N+1)/2 distinct weights are needed. No multiplier is used. Each weighted sum is built from a constant table that holds every possible sum of the distinct weights. One bit from each pre-added word addresses the table. The bit positions are handled one per pipeline stage, so a new result leaves the block on every clock.

The coefficients are given as a parameter at elaboration and are expressed in fixed point with FRAC fractional bits. The result is scaled back by FRAC bits, rounded and clipped to the sample width. Valid strobes travel with the data. Clocks that carry no sample leave the filter history untouched.

Top module: `sym_da_fir`

## Requirements
- R1: While rst_n is low and on the first clock after it is released, out_valid is 0 and out_data is 0.
- R2: The sample history advances only on clocks where in_valid is 1. Idle clocks between samples do not change any later result.
- R3: For history x[0] (newest) to x[N-1], the output is round(sum c(i)*x[i] / 2^FRAC). Here c(i) = c(N-1-i) = COEF field k = min(i, N-1-i), the field sits at bits [k*CW +: CW] as a two's-complement value, and field (N-1)/2 is the centre weight.
- R4: An all-zero history gives an output of exactly 0.
- R5: Rounding adds 2^(FRAC-1) before an arithmetic right shift by FRAC, so exact halves go toward plus infinity (for example -1.5 gives -1 and 1.5 gives 2).
- R6: Results above 2^(W-1)-1 are clipped to 2^(W-1)-1, and results below -2^(W-1) are clipped to -2^(W-1).
- R7: Each accepted sample produces exactly one output, in order. out_valid rises W+2 clock edges after the edge that captured the sample.
- R8: Samples presented on every clock give one output on every clock, with no bubbles.
- R9: The most negative sample value -2^(W-1) is weighted correctly. The top bit slice of the pre-added words counts with negative weight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one symbol per cycle at most |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_data holds a new sample this clock |
| in_data | input | W | Signed input sample |
| out_valid | output | 1 | out_data holds a new filtered result |
| out_data | output | W | Signed, rounded and clipped filter output |

## Verification
A long zero run and single impulses of different size and sign show each mirrored weight separately. They also separate a wrong pairing of taps from a wrong table entry. Impulses of plus and minus 32 land exactly on half steps, so they show whether rounding goes toward plus infinity. Alternating full-scale samples of opposite sign line up with the weight signs and drive both clip limits. These same samples use the most negative input, so they expose any wrong handling of the sign slice. Random samples with random idle gaps, followed by a long back-to-back random burst, test history gating, ordering, exact latency and full-rate throughput against a direct-form model.

// File: rtl/sym_da_pkg.sv
package sym_da_pkg;

    // width of one table entry: any sum of m weights of cw bits
    function automatic int lut_w(int cw, int m);
        return cw + $clog2(m) + 1;
    endfunction

    // accumulator width: table entry scaled by a (w+1)-bit pre-added word
    function automatic int acc_w(int w, int cw, int m);
        return lut_w(cw, m) + w + 2;
    endfunction

endpackage

// File: rtl/sym_da_lut.sv
module sym_da_lut #(
    parameter int M  = 4,
    parameter int CW = 8,
    parameter int LW = 11,
    parameter logic [M*CW-1:0] COEF = '0
) (
    input  logic [M-1:0]          addr,
    output logic signed [LW-1:0]  val
);
    localparam int ENTRIES = 2 ** M;

    // every subset sum of the distinct weights, fixed at elaboration
    function automatic logic [ENTRIES*LW-1:0] build_table();
        logic [ENTRIES*LW-1:0] t;
        longint s;
        t = '0;
        for (int a = 0; a < ENTRIES; a++) begin
            s = 0;
            for (int k = 0; k < M; k++) begin
                if (a[k]) s += longint'($signed(COEF[k*CW +: CW]));
            end
            t[a*LW +: LW] = LW'(s);
        end
        return t;
    endfunction

    localparam logic [ENTRIES*LW-1:0] TABLE = build_table();

    assign val = $signed(TABLE[addr*LW +: LW]);
endmodule

// File: rtl/sym_da_preadd.sv
module sym_da_preadd #(
    parameter int W     = 8,
    parameter int NTAPS = 7,
    parameter int M     = (NTAPS + 1) / 2,
    parameter int PW    = W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_data,
    output logic                 pre_valid,
    output logic [M*PW-1:0]      pre_words
);
    typedef struct packed {
        logic [NTAPS*W-1:0] taps;   // word 0 is the newest sample
        logic               vld_t;
        logic [M*PW-1:0]    pre;
        logic               vld_p;
    } st_t;

    st_t d, q;

    always_comb begin
        d = q;
        d.vld_t = in_valid;
        if (in_valid) d.taps = {q.taps[(NTAPS-1)*W-1:0], in_data};
        d.vld_p = q.vld_t;
        for (int k = 0; k < M; k++) begin
            if (k == M - 1)
                d.pre[k*PW +: PW] = PW'($signed(q.taps[k*W +: W]));
            else
                d.pre[k*PW +: PW] = PW'($signed(q.taps[k*W +: W]))
                                  + PW'($signed(q.taps[(NTAPS-1-k)*W +: W]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pre_valid = q.vld_p;
    assign pre_words = q.pre;

    // R2: history frozen on clocks without a sample
    a_r2_hold_history: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(q.taps));
endmodule

// File: rtl/sym_da_bitstage.sv
module sym_da_bitstage #(
    parameter int M   = 4,
    parameter int REM = 9,
    parameter int AW  = 21,
    parameter int LW  = 11,
    parameter int CW  = 8,
    parameter int BIT = 0,
    parameter logic [M*CW-1:0] COEF = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [M*REM-1:0]      in_sl,
    input  logic signed [AW-1:0]  in_acc,
    output logic                  out_vld,
    output logic [M*(REM-1)-1:0]  out_sl,
    output logic signed [AW-1:0]  out_acc
);
    typedef struct packed {
        logic                  vld;
        logic [M*(REM-1)-1:0]  sl;
        logic signed [AW-1:0]  acc;
    } st_t;

    st_t d, q;
    logic [M-1:0]          addr;
    logic [M*(REM-1)-1:0]  rest;
    logic signed [LW-1:0]  lv;

    always_comb begin
        addr = '0;
        rest = '0;
        for (int k = 0; k < M; k++) begin
            addr[k] = in_sl[k*REM];
            rest[k*(REM-1) +: REM-1] = in_sl[k*REM+1 +: REM-1];
        end
    end

    sym_da_lut #(.M(M), .CW(CW), .LW(LW), .COEF(COEF)) i_lut (
        .addr (addr),
        .val  (lv)
    );

    always_comb begin
        d.vld = in_vld;
        d.sl  = rest;
        d.acc = in_acc + ($signed({{(AW-LW){lv[LW-1]}}, lv}) <<< BIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_vld = q.vld;
    assign out_sl  = q.sl;
    assign out_acc = q.acc;

    // R4: an all-zero slice adds nothing
    a_r4_zero_slice: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && addr == '0) |=> (out_acc == $past(in_acc)));
    // R7: the valid tag moves one stage per clock
    a_r7_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_vld == $past(in_vld)));
endmodule

// File: rtl/sym_da_outfmt.sv
module sym_da_outfmt #(
    parameter int W    = 8,
    parameter int M    = 4,
    parameter int CW   = 8,
    parameter int LW   = 11,
    parameter int AW   = 21,
    parameter int FRAC = 6,
    parameter logic [M*CW-1:0] COEF = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [M-1:0]          in_sign,
    input  logic signed [AW-1:0]  in_acc,
    output logic                  out_valid,
    output logic signed [W-1:0]   out_data
);
    localparam int PW = W + 1;
    localparam logic signed [AW-1:0] MAXV = AW'((longint'(1) <<< (W-1)) - 1);
    localparam logic signed [AW-1:0] MINV = AW'(-(longint'(1) <<< (W-1)));
    localparam logic signed [AW-1:0] HALF = AW'(longint'(1) <<< (FRAC-1));
    localparam logic signed [AW-1:0] HI_T = AW'(longint'(1) <<< (W-1+FRAC));

    typedef struct packed {
        logic               vld;
        logic signed [W-1:0] data;
    } st_t;

    st_t d, q;
    logic signed [LW-1:0] lv;
    logic signed [AW-1:0] total, shf;

    sym_da_lut #(.M(M), .CW(CW), .LW(LW), .COEF(COEF)) i_lut (
        .addr (in_sign),
        .val  (lv)
    );

    always_comb begin
        // the sign slice carries weight -2^(PW-1)
        total = in_acc - ($signed({{(AW-LW){lv[LW-1]}}, lv}) <<< (PW-1));
        shf   = (total + HALF) >>> FRAC;
        d.vld = in_vld;
        if (shf > MAXV)      d.data = MAXV[W-1:0];
        else if (shf < MINV) d.data = MINV[W-1:0];
        else                 d.data = shf[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.vld;
    assign out_data  = q.data;

    // R6: a clearly oversized positive sum clips to the top code
    a_r6_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_sign == '0 && in_acc >= HI_T) |=> (out_data == MAXV[W-1:0]));
    // R1: no output without a tagged sum arriving
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_valid);
endmodule

// File: rtl/sym_da_fir.sv
module sym_da_fir
    import sym_da_pkg::*;
#(
    parameter int W     = 8,
    parameter int NTAPS = 7,
    parameter int CW    = 8,
    parameter int FRAC  = 6,
    parameter logic [((NTAPS+1)/2)*CW-1:0] COEF = 32'h40EC09FD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_data,
    output logic                out_valid,
    output logic signed [W-1:0] out_data
);
    localparam int M  = (NTAPS + 1) / 2;
    localparam int PW = W + 1;
    localparam int LW = lut_w(CW, M);
    localparam int AW = acc_w(W, CW, M);

    logic            pre_vld;
    logic [M*PW-1:0] pre_w;

    sym_da_preadd #(.W(W), .NTAPS(NTAPS), .M(M), .PW(PW)) i_preadd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .pre_valid (pre_vld),
        .pre_words (pre_w)
    );

    // one stage per magnitude bit slice, LSB first
    for (genvar b = 0; b < PW - 1; b++) begin : g_bit
        localparam int REM = PW - b;
        logic                  vld_i, vld_o;
        logic [M*REM-1:0]      sl_i;
        logic [M*(REM-1)-1:0]  sl_o;
        logic signed [AW-1:0]  acc_i, acc_o;

        if (b == 0) begin : g_head
            assign vld_i = pre_vld;
            assign sl_i  = pre_w;
            assign acc_i = '0;
        end else begin : g_link
            assign vld_i = g_bit[b-1].vld_o;
            assign sl_i  = g_bit[b-1].sl_o;
            assign acc_i = g_bit[b-1].acc_o;
        end

        sym_da_bitstage #(.M(M), .REM(REM), .AW(AW), .LW(LW), .CW(CW),
                          .BIT(b), .COEF(COEF)) i_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (vld_i),
            .in_sl   (sl_i),
            .in_acc  (acc_i),
            .out_vld (vld_o),
            .out_sl  (sl_o),
            .out_acc (acc_o)
        );
    end

    sym_da_outfmt #(.W(W), .M(M), .CW(CW), .LW(LW), .AW(AW), .FRAC(FRAC),
                    .COEF(COEF)) i_outfmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (g_bit[PW-2].vld_o),
        .in_sign   (g_bit[PW-2].sl_o),
        .in_acc    (g_bit[PW-2].acc_o),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: tb/test_sym_da_fir.sv
module test_sym_da_fir;
    localparam int W     = 8;
    localparam int NTAPS = 7;
    localparam int CW    = 8;
    localparam int FRAC  = 6;
    localparam int LAT   = W + 2;
    localparam logic [31:0] COEF = 32'h40EC09FD;   // -3, 9, -20, centre 64

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_data = '0;
    logic out_valid;
    logic signed [W-1:0] out_data;

    always #4 clk = ~clk;   // 125 MHz

    sym_da_fir #(.W(W), .NTAPS(NTAPS), .CW(CW), .FRAC(FRAC), .COEF(COEF)) i_sym_da_fir (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    typedef struct { int val; longint edge_n; string tag; } exp_t;
    exp_t   expq[$];
    int     hist[NTAPS];
    longint cyc = 0;
    int     n_cmp = 0;
    int     n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int coef_of(int i);
        int k;
        k = (i < NTAPS - 1 - i) ? i : NTAPS - 1 - i;
        return int'($signed(COEF[k*CW +: CW]));
    endfunction

    function automatic int model();
        longint s = 0;
        for (int i = 0; i < NTAPS; i++) s += longint'(coef_of(i)) * longint'(hist[i]);
        s = (s + (longint'(1) <<< (FRAC-1))) >>> FRAC;
        if (s > (2**(W-1)) - 1) s = (2**(W-1)) - 1;
        if (s < -(2**(W-1)))    s = -(2**(W-1));
        return int'(s);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(logic signed [W-1:0] x, string tag);
        exp_t e;
        for (int i = NTAPS - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = int'(x);
        e.val = model();
        e.edge_n = cyc + 1;
        e.tag = tag;
        expq.push_back(e);
        in_valid = 1'b1;
        in_data  = x;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
                check("R7 unexpected extra output", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(e.tag, int'(out_data), e.val);
                check("R7 latency", int'(cyc - e.edge_n), LAT);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd915));
        for (int i = 0; i < NTAPS; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 data in reset", int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", int'(out_valid), 0);
        check("R1 data after release", int'(out_data), 0);

        repeat (10) push('0, "R4 zero window");
        push(8'sd100, "R3 impulse +100");
        repeat (NTAPS + 1) push('0, "R3 impulse +100");
        push(-8'sd77, "R3 impulse -77");
        repeat (NTAPS + 1) push('0, "R3 impulse -77");
        push(8'sd32, "R5 half step +32");
        repeat (NTAPS + 1) push('0, "R5 half step +32");
        push(-8'sd32, "R5 half step -32");
        repeat (NTAPS + 1) push('0, "R5 half step -32");
        repeat (12) begin
            push(-8'sd128, "R6 R9 alternating full scale");
            push(8'sd127,  "R6 R9 alternating full scale");
        end
        repeat (NTAPS) push(-8'sd128, "R9 constant most negative");

        for (int i = 0; i < 150; i++) begin
            push($signed(W'($urandom)), "R2 gapped random");
            idle(int'($urandom_range(0, 3)));
        end
        for (int i = 0; i < 200; i++) push($signed(W'($urandom)), "R8 back-to-back random");

        idle(LAT + 6);
        check("R7 all outputs delivered", expq.size(), 0);
        summary();
        $finish;
    end
endmodule